// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sits beside the CPU core of a small 8-bit microcontroller and decides when the core clock and the main oscillator may run. Software selects a sleep mode by writing a power-control register. Idle stops the core and leaves the oscillator running. Soft power-down stops both. Hardware power-down is armed ahead of time by a register bit. It is then entered on its own when a power-fail sense pin falls from high to low. The block also drives a port-float request and a port preset that forces the port outputs high during reset.

Any enabled interrupt request ends idle or soft power-down. For each wake-up the block gives a one-cycle wake strobe and a resume indication. The indication tells the core either to continue at the instruction after the one that entered the mode, or to take the interrupt vector. Timer interrupts that are clocked externally during power-down are plain request lines here. The sequencer's own clock is treated as an always-on low-rate clock, so it can watch the pins while the main oscillator is off. Hardware power-down ends only with the reset pin.

Top module: `lpm_sequencer`

## Requirements
- R1: An active-low asynchronous reset puts the block in run mode, clears the register readback to 0 and holds cpu_clk_en and osc_en high. port_preset is high whenever reset is asserted, with no clock edge needed.
- R2: A register write in run mode with bit 0 = 1 and bit 1 = 0 enters idle on the next clock edge: cpu_clk_en goes low and osc_en stays high.
- R3: A register write in run mode with bit 1 = 1 enters soft power-down on the next edge, with cpu_clk_en and osc_en both low. When bits 0 and 1 are both written as 1, power-down wins and readback bit 0 reads 0. Readback bits 0 and 1 are never 1 together.
- R4: port_float equals float_cfg during soft and hardware power-down, and is 0 in run and idle.
- R5: In idle or soft power-down, a high level on any irq_req bit returns the block to run mode on the next edge. The same edge raises wake_pulse for exactly one cycle and clears readback bits 0 and 1.
- R6: During wake_pulse, wake_resume equals register bit 5 as last written: 1 means continue at the next instruction, 0 means take the interrupt vector. Bit 5 reads back unchanged after wake-up.
- R7: When register bit 6 is 1, a high-to-low transition of pfail_n in run or idle enters hardware power-down on the third clock edge after the pin falls, with cpu_clk_en and osc_en low.
- R8: A fall of pfail_n with bit 6 clear has no effect. Arming bit 6 while pfail_n is already low does not trigger entry.
- R9: In hardware power-down, irq_req is ignored: no wake_pulse, and the block stays stopped until reset.
- R10: Register writes made while not in run mode are ignored: readback and the enables stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset pin |
| ctl_wr | input | 1 | Power-control register write strobe |
| ctl_wdata | input | 8 | Register write data (bit0 idle, bit1 power-down, bit5 resume, bit6 arm) |
| float_cfg | input | 1 | Float ports during power-down when 1 |
| pfail_n | input | 1 | Power-fail sense pin, asynchronous, low = failing |
| irq_req | input | NUM_IRQ | Interrupt request lines (wake sources) |
| ctl_rd | output | 8 | Register readback |
| cpu_clk_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Main oscillator enable |
| port_float | output | 1 | Ports to floating state |
| port_preset | output | 1 | Force port outputs high (during reset) |
| wake_pulse | output | 1 | One-cycle wake-up strobe |
| wake_resume | output | 1 | 1 = resume at next instruction, 0 = vector |

## Verification
The bench sweeps the resume selection, the three write codes (idle only, power-down only, both bits) and each individual interrupt line. float_cfg alternates along the sweep. This separates idle from power-down through osc_en and port_float, and shows that every line wakes the block with the right resume flag. Writes made during sleep show whether the register is shielded. The power-fail pin is exercised in three cases: falling unarmed, already low when armed, and falling after arming. The second case separates true edge detection from level sensing. The exact cycle of entry is checked. Interrupts during hardware power-down, followed by reset, confirm that only reset ends that mode.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_IDLE = 2'd1,
        MODE_SPD  = 2'd2,
        MODE_HPD  = 2'd3
    } lpm_mode_e;

    // register field positions
    localparam int BIT_IDLE   = 0;
    localparam int BIT_PD     = 1;
    localparam int BIT_RESUME = 5;
    localparam int BIT_ARM    = 6;

    typedef struct packed {
        lpm_mode_e mode;
        logic      idle_bit;
        logic      pd_bit;
        logic      resume_sel;
        logic      arm;
        logic      wake;
        logic      wake_resume;
    } lpm_state_t;

endpackage

// File: rtl/lpm_fall_sync.sv
module lpm_fall_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], pin};
    end

    // resets low so that a pin already high after reset is a rise, not a fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign fall = sh_q[W-1] & ~sh_q[W-2];

    // R8
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/lpm_wake_merge.sv
module lpm_wake_merge #(
    parameter int               NUM_IRQ   = 6,
    parameter logic [NUM_IRQ-1:0] WAKE_MASK = '1
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    output logic               any_wake
);
    logic [NUM_IRQ:0] chain;

    assign chain[0] = 1'b0;
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_or
        if (WAKE_MASK[i]) begin : g_en
            assign chain[i+1] = chain[i] | irq_req[i];
        end else begin : g_dis
            assign chain[i+1] = chain[i];
        end
    end
    assign any_wake = chain[NUM_IRQ];

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int NUM_IRQ     = 6,
    parameter int SYNC_STAGES = 2,
    parameter int REG_W       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic [REG_W-1:0]   ctl_wdata,
    input  logic               float_cfg,
    input  logic               pfail_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    output logic [REG_W-1:0]   ctl_rd,
    output logic               cpu_clk_en,
    output logic               osc_en,
    output logic               port_float,
    output logic               port_preset,
    output logic               wake_pulse,
    output logic               wake_resume
);

    logic pfail_fall;
    logic irq_any;
    lpm_state_t s_d, s_q;

    lpm_fall_sync #(.STAGES(SYNC_STAGES)) pin_sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pfail_n),
        .fall (pfail_fall)
    );

    lpm_wake_merge #(.NUM_IRQ(NUM_IRQ)) wake_i (
        .irq_req (irq_req),
        .any_wake(irq_any)
    );

    logic hpd_hit;
    assign hpd_hit = s_q.arm & pfail_fall;

    always_comb begin
        s_d             = s_q;
        s_d.wake        = 1'b0;
        s_d.wake_resume = 1'b0;
        unique case (s_q.mode)
            MODE_RUN: begin
                if (ctl_wr) begin
                    s_d.resume_sel = ctl_wdata[BIT_RESUME];
                    s_d.arm        = ctl_wdata[BIT_ARM];
                    s_d.pd_bit     = ctl_wdata[BIT_PD];
                    s_d.idle_bit   = ctl_wdata[BIT_IDLE] & ~ctl_wdata[BIT_PD];
                    if (ctl_wdata[BIT_PD])        s_d.mode = MODE_SPD;
                    else if (ctl_wdata[BIT_IDLE]) s_d.mode = MODE_IDLE;
                end
                if (hpd_hit) begin
                    s_d.mode     = MODE_HPD;
                    s_d.idle_bit = 1'b0;
                    s_d.pd_bit   = 1'b0;
                end
            end
            MODE_IDLE, MODE_SPD: begin
                if (hpd_hit && s_q.mode == MODE_IDLE) begin
                    s_d.mode     = MODE_HPD;
                    s_d.idle_bit = 1'b0;
                end else if (irq_any) begin
                    s_d.mode        = MODE_RUN;
                    s_d.idle_bit    = 1'b0;
                    s_d.pd_bit      = 1'b0;
                    s_d.wake        = 1'b1;
                    s_d.wake_resume = s_q.resume_sel;
                end
            end
            default: ;  // hardware power-down: only reset leaves
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: MODE_RUN, default: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ctl_rd              = '0;
        ctl_rd[BIT_IDLE]    = s_q.idle_bit;
        ctl_rd[BIT_PD]      = s_q.pd_bit;
        ctl_rd[BIT_RESUME]  = s_q.resume_sel;
        ctl_rd[BIT_ARM]     = s_q.arm;
    end

    assign cpu_clk_en  = (s_q.mode == MODE_RUN);
    assign osc_en      = (s_q.mode == MODE_RUN) || (s_q.mode == MODE_IDLE);
    assign port_float  = float_cfg && ((s_q.mode == MODE_SPD) || (s_q.mode == MODE_HPD));
    assign port_preset = ~rst_n;
    assign wake_pulse  = s_q.wake;
    assign wake_resume = s_q.wake_resume;

    // R9
    hpd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_HPD) |=> (s_q.mode == MODE_HPD));

    // R7
    hpd_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.mode == MODE_HPD) |-> $past(s_q.arm));

    // R5
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wake |-> ($past(irq_any) &&
                      ($past(s_q.mode) == MODE_IDLE || $past(s_q.mode) == MODE_SPD)));

    // R3
    one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_rd[BIT_IDLE] && ctl_rd[BIT_PD]));

    // R4
    float_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_float |-> !osc_en);

    // R10
    sleep_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && !wake_pulse && $past(!cpu_clk_en)) |-> $stable(ctl_rd[BIT_ARM]));

endmodule

// File: tb/lpm_sequencer_tb.sv
module lpm_sequencer_tb_top;

    localparam int NI = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [7:0]    ctl_wdata = '0;
    logic          float_cfg = 1'b0;
    logic          pfail_n = 1'b1;
    logic [NI-1:0] irq_req = '0;
    logic [7:0]    ctl_rd;
    logic          cpu_clk_en, osc_en, port_float, port_preset, wake_pulse, wake_resume;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lpm_sequencer #(.NUM_IRQ(NI)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .float_cfg(float_cfg), .pfail_n(pfail_n), .irq_req(irq_req),
        .ctl_rd(ctl_rd), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
        .port_float(port_float), .port_preset(port_preset),
        .wake_pulse(wake_pulse), .wake_resume(wake_resume)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pc_write(input logic [7:0] d);
        ctl_wr = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #1;
        chk("R1 preset", 32'(port_preset), 1);
        wait_neg(2);
        rst_n = 1'b1;
        wait_neg(4);
        chk("R1 cpu", 32'(cpu_clk_en), 1);
        chk("R1 osc", 32'(osc_en), 1);
        chk("R1 reg", 32'(ctl_rd), 0);
        chk("R1 preset off", 32'(port_preset), 0);

        // sweep: resume select x write code x irq line
        for (int rs = 0; rs < 2; rs++) begin
            for (int m = 0; m < 3; m++) begin
                for (int k = 0; k < NI; k++) begin
                    logic [7:0] code, exp_rd;
                    code = (m == 0) ? 8'h01 : (m == 1) ? 8'h02 : 8'h03;
                    float_cfg = k[0];
                    pc_write(8'(rs << 5) | code);
                    exp_rd = 8'(rs << 5) | ((m == 0) ? 8'h01 : 8'h02);
                    chk("R2/R3 cpu", 32'(cpu_clk_en), 0);
                    chk("R2/R3 osc", 32'(osc_en), (m == 0) ? 1 : 0);
                    chk("R3 reg", 32'(ctl_rd), 32'(exp_rd));
                    chk("R4 float", 32'(port_float), (m != 0 && k[0]) ? 1 : 0);
                    if (k == 0) begin
                        pc_write(8'h42);
                        chk("R10 reg", 32'(ctl_rd), 32'(exp_rd));
                        chk("R10 osc", 32'(osc_en), (m == 0) ? 1 : 0);
                    end
                    irq_req = NI'(1 << k);
                    @(negedge clk);
                    irq_req = '0;
                    chk("R5 pulse", 32'(wake_pulse), 1);
                    chk("R5 cpu", 32'(cpu_clk_en), 1);
                    chk("R6 resume", 32'(wake_resume), 32'(rs));
                    chk("R5/R6 reg", 32'(ctl_rd), 32'(rs << 5));
                    @(negedge clk);
                    chk("R5 pulse one", 32'(wake_pulse), 0);
                end
            end
        end

        // hardware power-down
        float_cfg = 1'b1;
        pfail_n = 1'b0;
        wait_neg(4);
        chk("R8 unarmed", 32'(cpu_clk_en), 1);
        pfail_n = 1'b1;
        wait_neg(3);
        pfail_n = 1'b0;
        wait_neg(4);
        pc_write(8'h40);
        wait_neg(4);
        chk("R8 low at arm", 32'(cpu_clk_en), 1);
        chk("R8 reg", 32'(ctl_rd), 32'h40);
        pfail_n = 1'b1;
        wait_neg(3);
        pfail_n = 1'b0;
        wait_neg(2);
        chk("R7 not yet", 32'(cpu_clk_en), 1);
        @(negedge clk);
        chk("R7 cpu", 32'(cpu_clk_en), 0);
        chk("R7 osc", 32'(osc_en), 0);
        chk("R4 float hpd", 32'(port_float), 1);
        irq_req = '1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 no wake", 32'(wake_pulse), 0);
            chk("R9 stay", 32'(cpu_clk_en), 0);
        end
        irq_req = '0;
        rst_n = 1'b0;
        #1;
        chk("R1 preset async", 32'(port_preset), 1);
        chk("R9 reset exit", 32'(cpu_clk_en), 1);
        chk("R1 reg clear", 32'(ctl_rd), 0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_neg(2);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule